// File: doc/BRIEF.md
# I2C Slave Transmitter with Status Codes

This block is the read-only half of an I2C slave. It watches the bus through two-flop synchronisers, decodes START and STOP from SDA edges taken while SCL is high, and compares each incoming address byte with a 7-bit own address. When a master asks to read from that address, the block acknowledges and then shifts out data bytes supplied by the host one at a time. Both bus lines are open-drain: the block only ever pulls a line low or lets it go.

Every bus event the host must act on sets an event flag and loads a numeric status code. While the flag is set the block holds SCL low, so the master waits. The host reads the code, writes the next byte to the transmit register, and then pulses a flag-clear strobe. With the flag clear the status reads the idle code F8h.

A response-enable input lets the host end a read cleanly. If the enable is low when the host clears the flag to release a byte, that byte is the final one. Once it has been sent the block stops taking part in the transfer, and the master then reads only ones. While the enable stays low the block answers no address. Raising it again restores address recognition from the next address byte.

Top module: `i2c_tslave`

## Requirements
- R1: In the first cycle after reset the event flag is 0, the status reads F8h and neither bus line is pulled low.
- R2: The block pulls SDA low in the acknowledge slot of an address byte only when all of these hold: bits 7..1 of the byte equal the own address, bit 0 (the direction bit) is 1, and the response enable is high. In every other case SDA stays released in that slot and the event flag is not set.
- R3: The address value 0 is never acknowledged, in either direction, even when the own address is 0.
- R4: After an acknowledged address, the event flag is set when SCL falls at the end of the acknowledge slot, and the status reads A8h.
- R5: While the event flag is set, SCL is held low and the status holds its code. A flag-clear pulse clears the flag in the next cycle and releases SCL. Whenever the flag is clear the status reads F8h.
- R6: Each data byte is the transmit-register value present in the cycle of the flag-clear pulse, sent MSB first. SDA changes only while SCL is low, and SDA is released during the master's acknowledge slot.
- R7: After each data byte the flag is set at the falling edge of the acknowledge slot, with one of these codes: B8h when the master acknowledged and the byte was not the final one; C0h when the master did not acknowledge; C8h when the master acknowledged and the byte was the final one.
- R8: A byte is the final one when the response enable is low in the very cycle of the flag-clear pulse that releases it. A low enable in any other cycle does not make it final. After a C0h or C8h code is cleared, the block releases SDA, requests no further byte and sets no flag, and the master reads FFh, until the next START.
- R9: While the response enable is low, no address is acknowledged. Raising the enable again makes the next own-address read acknowledged.
- R10: A START (SDA falling while SCL is high) restarts address reception from any point, including partway through an address byte. A STOP (SDA rising while SCL is high) returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Level on the SCL wire |
| sda_i | input | 1 | Level on the SDA wire |
| scl_pull_o | output | 1 | 1 pulls SCL low (open-drain) |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain) |
| own_addr_i | input | 7 | Own 7-bit slave address |
| ack_en_i | input | 1 | Response enable |
| tx_byte_i | input | 8 | Transmit data register |
| flag_clr_i | input | 1 | One-cycle strobe that clears the event flag |
| flag_o | output | 1 | Event flag |
| status_o | output | 8 | Status code, F8h when the flag is clear |

## Verification
Two host actions can land in the same clock cycle: clearing the response enable, and the flag-clear strobe that releases a byte. The bench drops the enable exactly in the strobe cycle for one byte, and expects C8h after that byte and FFh on every later read. It also drops the enable one cycle after the strobe for another byte, and expects B8h with normal data to follow. Random reads then mix address hits, misses, write requests and final-byte choices, and each is checked against sequences of codes and bytes that bench functions compute.

// File: rtl/i2c_tslave_pkg.sv
package i2c_tslave_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 7;

  localparam logic [DATA_W-1:0] CODE_NONE     = 8'hF8;
  localparam logic [DATA_W-1:0] CODE_ADDR_RD  = 8'hA8;
  localparam logic [DATA_W-1:0] CODE_TX_ACK   = 8'hB8;
  localparam logic [DATA_W-1:0] CODE_TX_NACK  = 8'hC0;
  localparam logic [DATA_W-1:0] CODE_LAST_ACK = 8'hC8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_ADDR_ACK,
    PH_SEND,
    PH_SEND_ACK,
    PH_HOLD,
    PH_DETACH
  } phase_t;
endpackage

// File: rtl/i2c_tslave_sync.sv
module i2c_tslave_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= '1;
        else     chain[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= '1;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_tslave_cond.sv
module i2c_tslave_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_rise  =  scl & ~scl_q;
  assign scl_fall  = ~scl &  scl_q;
  assign bus_start =  scl &  scl_q &  sda_q & ~sda;
  assign bus_stop  =  scl &  scl_q & ~sda_q &  sda;
endmodule

// File: rtl/i2c_tslave_ctrl.sv
module i2c_tslave_ctrl
  import i2c_tslave_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ack_en,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              flag_clr,
  output logic              scl_pull,
  output logic              sda_pull,
  output logic              flag,
  output logic [DATA_W-1:0] status
);
  localparam int CNT_W = $clog2(DATA_W + 2);

  phase_t             phase;
  logic [DATA_W-1:0]  shreg;
  logic [CNT_W-1:0]   bitcnt;
  logic               last_q;
  logic               acked_q;

  logic [DATA_W-1:0]  addr_byte;
  logic               addr_hit;

  assign addr_byte = {shreg[DATA_W-2:0], sda_lvl};
  assign addr_hit  = ack_en && addr_byte[0] &&
                     (addr_byte[DATA_W-1:1] == own_addr) &&
                     (addr_byte[DATA_W-1:1] != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      shreg    <= '0;
      bitcnt   <= '0;
      last_q   <= 1'b0;
      acked_q  <= 1'b0;
      scl_pull <= 1'b0;
      sda_pull <= 1'b0;
      flag     <= 1'b0;
      status   <= CODE_NONE;
    end else if (flag && flag_clr) begin
      flag     <= 1'b0;
      status   <= CODE_NONE;
      scl_pull <= 1'b0;
      if (status == CODE_ADDR_RD || status == CODE_TX_ACK) begin
        sda_pull <= ~tx_byte[DATA_W-1];
        shreg    <= {tx_byte[DATA_W-2:0], 1'b0};
        bitcnt   <= '0;
        last_q   <= ~ack_en;
        phase    <= PH_SEND;
      end else begin
        sda_pull <= 1'b0;
        phase    <= PH_DETACH;
      end
    end else if (bus_start) begin
      phase    <= PH_ADDR;
      bitcnt   <= '0;
      sda_pull <= 1'b0;
    end else if (bus_stop) begin
      phase    <= PH_IDLE;
      sda_pull <= 1'b0;
    end else begin
      case (phase)
        PH_ADDR: begin
          if (scl_rise) begin
            shreg  <= addr_byte;
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == CNT_W'(DATA_W - 1)) begin
              phase <= addr_hit ? PH_ADDR_ACK : PH_IDLE;
            end
          end
        end
        PH_ADDR_ACK: begin
          if (scl_fall) begin
            if (bitcnt == CNT_W'(DATA_W)) begin
              sda_pull <= 1'b1;
              bitcnt   <= bitcnt + 1'b1;
            end else begin
              sda_pull <= 1'b0;
              scl_pull <= 1'b1;
              flag     <= 1'b1;
              status   <= CODE_ADDR_RD;
              phase    <= PH_HOLD;
            end
          end
        end
        PH_SEND: begin
          if (scl_fall) begin
            if (bitcnt == CNT_W'(DATA_W - 1)) begin
              sda_pull <= 1'b0;
              phase    <= PH_SEND_ACK;
            end else begin
              sda_pull <= ~shreg[DATA_W-1];
              shreg    <= {shreg[DATA_W-2:0], 1'b0};
              bitcnt   <= bitcnt + 1'b1;
            end
          end
        end
        PH_SEND_ACK: begin
          if (scl_rise) begin
            acked_q <= ~sda_lvl;
          end else if (scl_fall) begin
            scl_pull <= 1'b1;
            flag     <= 1'b1;
            status   <= !acked_q ? CODE_TX_NACK :
                        (last_q ? CODE_LAST_ACK : CODE_TX_ACK);
            phase    <= PH_HOLD;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_tslave.sv
module i2c_tslave
  import i2c_tslave_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_pull_o,
  output logic              sda_pull_o,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              ack_en_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  input  logic              flag_clr_i,
  output logic              flag_o,
  output logic [DATA_W-1:0] status_o
);
  logic [1:0] line_sync;
  logic       scl_rise, scl_fall, bus_start, bus_stop;

  i2c_tslave_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_i, sda_i}),
    .q   (line_sync)
  );

  i2c_tslave_cond u_cond (
    .clk       (clk),
    .rst       (rst),
    .scl       (line_sync[1]),
    .sda       (line_sync[0]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop)
  );

  i2c_tslave_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .sda_lvl   (line_sync[0]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .own_addr  (own_addr_i),
    .ack_en    (ack_en_i),
    .tx_byte   (tx_byte_i),
    .flag_clr  (flag_clr_i),
    .scl_pull  (scl_pull_o),
    .sda_pull  (sda_pull_o),
    .flag      (flag_o),
    .status    (status_o)
  );
endmodule

// File: rtl/i2c_tslave_chk.sv
module i2c_tslave_chk (
  input logic       clk,
  input logic       rst,
  input logic       scl_i,
  input logic       flag_o,
  input logic       flag_clr_i,
  input logic [7:0] status_o,
  input logic       scl_pull_o,
  input logic       sda_pull_o
);
  AST_STRETCH_WHILE_FLAG: assert property (@(posedge clk) disable iff (rst)
    flag_o |-> scl_pull_o); // R5

  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (rst)
    !flag_o |-> status_o == 8'hF8); // R5

  AST_FLAG_HELD: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !flag_clr_i) |=> (flag_o && $stable(status_o))); // R5

  AST_CLEAR_DROPS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (flag_o && flag_clr_i) |=> !flag_o); // R5

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    flag_o |-> (status_o inside {8'hA8, 8'hB8, 8'hC0, 8'hC8})); // R7

  AST_SDA_MOVES_WITH_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_pull_o) |-> !$past(scl_i)); // R6
endmodule

bind i2c_tslave i2c_tslave_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .scl_i      (scl_i),
  .flag_o     (flag_o),
  .flag_clr_i (flag_clr_i),
  .status_o   (status_o),
  .scl_pull_o (scl_pull_o),
  .sda_pull_o (sda_pull_o)
);

// File: tb/i2c_tslave_tb.sv
module i2c_tslave_tb;
  localparam int Q = 10;
  localparam int H = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       scl_pull, sda_pull;
  logic       scl_bus, sda_bus;
  logic [6:0] own_addr = 7'h35;
  logic       ack_base = 1'b1, ack_kill = 1'b0, ack_en;
  logic [7:0] tx_byte = 8'h00;
  logic       flag_clr = 1'b0;
  logic       flag;
  logic [7:0] status;

  int nchk = 0, nerr = 0;
  bit done = 0;
  logic [7:0] txq [0:255];
  logic [7:0] rx  [0:15];
  logic [7:0] stat_log [0:255];
  int tx_rd = 0, stat_n = 0;
  int clr_at_load = -1, late_at_load = -1;

  always #4 clk = ~clk;

  assign scl_bus = scl_m & ~scl_pull;
  assign sda_bus = sda_m & ~sda_pull;
  assign ack_en  = ack_base & ~ack_kill;

  i2c_tslave u_dut (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl_bus),
    .sda_i      (sda_bus),
    .scl_pull_o (scl_pull),
    .sda_pull_o (sda_pull),
    .own_addr_i (own_addr),
    .ack_en_i   (ack_en),
    .tx_byte_i  (tx_byte),
    .flag_clr_i (flag_clr),
    .flag_o     (flag),
    .status_o   (status)
  );

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic raise_scl();
    scl_m = 1'b1;
    do @(negedge clk); while (scl_bus !== 1'b1);
  endtask

  task automatic send_bit(bit b);
    sda_m = b; cyc(Q); raise_scl(); cyc(H); scl_m = 1'b0; cyc(Q);
  endtask

  task automatic recv_bit(output bit b);
    sda_m = 1'b1; cyc(Q); raise_scl(); cyc(H/2);
    b = sda_bus; cyc(H/2); scl_m = 1'b0; cyc(Q);
  endtask

  task automatic start_c();
    sda_m = 1'b1; scl_m = 1'b1; cyc(H); sda_m = 1'b0; cyc(H); scl_m = 1'b0; cyc(Q);
  endtask

  task automatic rep_start();
    sda_m = 1'b1; cyc(Q); raise_scl(); cyc(H); sda_m = 1'b0; cyc(H); scl_m = 1'b0; cyc(Q);
  endtask

  task automatic stop_c();
    sda_m = 1'b0; cyc(Q); raise_scl(); cyc(H); sda_m = 1'b1; cyc(H);
  endtask

  task automatic read_body(input logic [7:0] ab, input int n, output bit ackd);
    bit b;
    for (int i = 7; i >= 0; i--) send_bit(ab[i]);
    recv_bit(b);
    ackd = !b;
    if (ackd) begin
      for (int j = 0; j < n; j++) begin
        logic [7:0] v;
        for (int i = 7; i >= 0; i--) begin
          recv_bit(b);
          v[i] = b;
        end
        rx[j] = v;
        send_bit(j == n - 1);
      end
    end
    stop_c();
  endtask

  function automatic logic [7:0] exp_code(int j, int n, int lastj);
    if (j == n - 1) return 8'hC0;
    if (j == lastj) return 8'hC8;
    return 8'hB8;
  endfunction

  // Run one read; last_rel / late_rel are byte indices within this read, or -1.
  task automatic run_case(input logic [7:0] ab, input int n, input int last_rel,
                          input int late_rel, input bit exp_ack, input string rq,
                          input bit partial_first);
    int base, sn0, lastj, nst;
    bit ackd;
    base = tx_rd;
    sn0  = stat_n;
    for (int j = 0; j < n; j++) txq[(base + j) % 256] = 8'($urandom);
    clr_at_load  = (last_rel >= 0) ? base + last_rel : -1;
    late_at_load = (late_rel >= 0) ? base + late_rel : -1;
    start_c();
    if (partial_first) begin
      for (int i = 0; i < 4; i++) send_bit(i[0]);
      rep_start();
    end
    read_body(ab, n, ackd);
    cyc(40);
    chk(ackd == exp_ack, rq, "address acknowledge", ackd, exp_ack);
    lastj = (last_rel >= 0) ? last_rel : n - 1;
    if (exp_ack && ackd) begin
      for (int j = 0; j < n; j++) begin
        logic [7:0] e;
        e = (j <= lastj) ? txq[(base + j) % 256] : 8'hFF;
        chk(rx[j] == e, (j <= lastj) ? "R6" : "R8", "read byte", rx[j], e);
      end
      nst = 1 + lastj + 1;
      chk(stat_n - sn0 == nst, "R7", "event count", stat_n - sn0, nst);
      if (stat_n - sn0 == nst) begin
        chk(stat_log[sn0] == 8'hA8, "R4", "address code", stat_log[sn0], 8'hA8);
        for (int j = 0; j <= lastj; j++)
          chk(stat_log[sn0 + 1 + j] == exp_code(j, n, lastj), "R7", "byte code",
              stat_log[sn0 + 1 + j], exp_code(j, n, lastj));
      end
      chk(tx_rd == base + lastj + 1, "R8", "bytes requested", tx_rd, base + lastj + 1);
    end else begin
      chk(stat_n == sn0, rq, "no event on miss", stat_n - sn0, 0);
    end
    chk(!flag && status == 8'hF8 && !scl_pull && !sda_pull, "R5", "idle after read",
        status, 8'hF8);
    clr_at_load = -1;
    late_at_load = -1;
  endtask

  // Host software model
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && flag) begin
        logic [7:0] st;
        int ld;
        chk(scl_bus == 1'b0, "R5", "SCL low with flag", scl_bus, 0);
        cyc(6);
        chk(flag && scl_bus == 1'b0, "R5", "stretch held", scl_bus, 0);
        st = status;
        stat_log[stat_n % 256] = st;
        stat_n++;
        ld = -1;
        if (st == 8'hA8 || st == 8'hB8) begin
          ld = tx_rd;
          tx_byte = txq[tx_rd % 256];
          tx_rd++;
        end
        if (ld >= 0 && ld == clr_at_load) ack_kill = 1'b1;
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        ack_kill = 1'b0;
        if (ld >= 0 && ld == late_at_load) ack_kill = 1'b1;
        chk(!flag && status == 8'hF8, "R5", "flag cleared reads F8", status, 8'hF8);
        @(negedge clk);
        ack_kill = 1'b0;
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk(!flag && status == 8'hF8 && !scl_pull && !sda_pull, "R1", "reset state",
        status, 8'hF8);
    cyc(20);

    // Directed: normal read of 3 bytes
    run_case({own_addr, 1'b1}, 3, -1, -1, 1, "R2", 0);
    // Write direction to own address: ignored
    run_case({own_addr, 1'b0}, 1, -1, -1, 0, "R2", 0);
    // Other address
    run_case({own_addr ^ 7'h01, 1'b1}, 1, -1, -1, 0, "R2", 0);
    // Address 0 with own address 0
    own_addr = 7'h00;
    run_case(8'h01, 1, -1, -1, 0, "R3", 0);
    run_case(8'h00, 1, -1, -1, 0, "R3", 0);
    own_addr = 7'h35;
    // Enable low: no response, then restored
    ack_base = 1'b0;
    run_case({own_addr, 1'b1}, 1, -1, -1, 0, "R9", 0);
    ack_base = 1'b1;
    run_case({own_addr, 1'b1}, 2, -1, -1, 1, "R9", 0);
    // Enable dropped in the strobe cycle of byte 1: final byte, C8, then FFh
    run_case({own_addr, 1'b1}, 4, 1, -1, 1, "R8", 0);
    // Enable dropped one cycle after the strobe: no effect
    run_case({own_addr, 1'b1}, 3, -1, 0, 1, "R8", 0);
    // Final byte on the first byte
    run_case({own_addr, 1'b1}, 2, 0, -1, 1, "R8", 0);
    // Single byte read ending in NACK
    run_case({own_addr, 1'b1}, 1, -1, -1, 1, "R7", 0);
    // Repeated START partway through an address byte
    run_case({own_addr, 1'b1}, 2, -1, -1, 1, "R10", 1);

    // Random reads
    for (int t = 0; t < 14; t++) begin
      int kind, n, lr, lt;
      logic [7:0] ab;
      bit ex;
      own_addr = 7'($urandom_range(1, 127));
      kind = $urandom_range(0, 3);
      n  = $urandom_range(1, 4);
      lr = $urandom_range(0, 2) == 0 ? $urandom_range(0, n - 1) : -1;
      lt = $urandom_range(0, 2) == 0 ? $urandom_range(0, n - 1) : -1;
      if (lt == lr) lt = -1;
      if (lr >= 0 && lt > lr) lt = -1;
      case (kind)
        0: begin ab = {own_addr ^ 7'($urandom_range(1, 127)), 1'b1}; ex = 0; end
        1: begin ab = {own_addr, 1'b0}; ex = 0; end
        default: begin ab = {own_addr, 1'b1}; ex = 1; end
      endcase
      run_case(ab, n, lr, lt, ex, "R2", 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule